// File: doc/BRIEF.md
# Parallel port FIFO control register

This block holds the extended control register and the byte FIFO of a parallel port that has a FIFO. It sits behind a host register bus, on the low two offset bits of the port's upper register window (0x400, 0x401, 0x402). The FIFO has two stream sides. One faces the host and the other faces the peripheral-side handshake logic, which lives outside this block. A direction input decides which side fills the FIFO and which side drains it. In test mode the host both fills and drains it.

A single status and control byte reports whether the FIFO is empty or full. It selects the port mode, enables DMA, masks the error interrupt and holds the service bit. The service bit is set by hardware and cleared by software. While it is clear, the block raises a service interrupt on one of three conditions. In DMA mode the condition is a terminal count. In programmed I/O it is a free-space threshold when the FIFO runs forward, or a fill threshold when it runs in reverse. While the service bit is set, service interrupts and DMA requests are both held off. A falling edge on the active-low fault input raises a one-cycle error pulse in ECP mode. Clearing the error mask while the fault is low also raises the pulse, so no fault is lost between a register read and the write that follows it.

All data pins use valid/ready. A byte moves on a clock edge where both are high. Valid never waits for ready. A filling side sees ready low while the FIFO is full, and a draining side sees valid low while it is empty. Both sides see their handshake held low in any mode other than 010, 011 and 110.

Top module: `ecp_fifo_ctrl`

## Requirements
- R1: After reset the control byte at offset 2 reads 0x05. That is mode 000, error mask 0, DMA enable 0, service bit (bit 2) 1, full (bit 1) 0 and empty (bit 0) 1. After reset svc_irq, dma_req and err_irq are low.
- R2: Bit 0 of the control byte reads 1 exactly when the FIFO holds no bytes. Bit 1 reads 1 exactly when it holds DEPTH bytes. Writes to bits 1:0 are ignored. Bits 7:5 hold the mode, bit 4 the error mask and bit 3 the DMA enable.
- R3: The FIFO returns bytes in the order they were accepted. A filling side sees ready low when the FIFO is full. In test mode (110) the host fills and drains, and the head byte is read out whatever the direction input is.
- R4: In modes 010 and 011 with dir_rev=0, the host fills and the peripheral drains. With dir_rev=1, the peripheral fills and the host drains. In modes 000, 001, 100, 101 and 111, every stream ready and valid output is low.
- R5: In a FIFO mode with DMA off and dir_rev=0, svc_irq is high when the service bit is 0 and the free slots are at least WR_TH. The service bit becomes 1 on that same clock edge.
- R6: In a FIFO mode with DMA off and dir_rev=1, svc_irq is high when the service bit is 0 and the stored bytes are at least RD_TH. Below RD_TH it stays low.
- R7: With DMA enabled, svc_irq follows dma_tc and ignores the thresholds. dma_req is high when the service bit is 0 and the FIFO can move a byte: not full for dir_rev=0, not empty for dir_rev=1. With DMA off, dma_req stays low.
- R8: While the service bit is 1, svc_irq and dma_req are low. After it has been set by hardware it reads back as 1 until software writes 0.
- R9: In mode 011 with the error mask 0, a high-to-low change of fault_n gives a one-cycle err_irq pulse. With the mask at 1, or in any other mode, the change gives no pulse.
- R10: In mode 011, a write that changes the error mask from 1 to 0 while fault_n is low raises err_irq in the cycle of that write.
- R11: In mode 111, offset 0 reads 0x10 and offset 1 reads 0x00. In other modes both read 0x00. Writes to offsets 0 and 1 have no effect.
- R12: A write that moves the mode from a value other than 000 or 001 into 000 or 001 empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register offset (0, 1, 2) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dir_rev | input | 1 | FIFO direction: 0 host to peripheral, 1 peripheral to host |
| host_wvalid | input | 1 | Host byte offered to FIFO |
| host_wready | output | 1 | FIFO accepts host byte |
| host_wdata | input | 8 | Host byte in |
| host_rvalid | output | 1 | FIFO head byte offered to host |
| host_rready | input | 1 | Host takes head byte |
| host_rdata | output | 8 | Head byte to host |
| per_wvalid | input | 1 | Peripheral byte offered to FIFO |
| per_wready | output | 1 | FIFO accepts peripheral byte |
| per_wdata | input | 8 | Peripheral byte in |
| per_rvalid | output | 1 | FIFO head byte offered to peripheral |
| per_rready | input | 1 | Peripheral takes head byte |
| per_rdata | output | 8 | Head byte to peripheral |
| dma_tc | input | 1 | DMA terminal count reached |
| dma_req | output | 1 | DMA request |
| svc_irq | output | 1 | Service interrupt |
| fault_n | input | 1 | Active-low fault from the peripheral |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
The bench builds the block with its defaults: a 16-byte FIFO and both thresholds at 8. With those values a full FIFO is reached in sixteen pushes. Both threshold boundaries can be met a single byte away: seven free slots against eight, and seven stored bytes against eight. The test-mode run fills the FIFO to capacity, so the full flag, the back-pressure on the host side and the pointer wrap are all exercised.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STD   = 3'b000,
    MD_BIDIR = 3'b001,
    MD_PFIFO = 3'b010,
    MD_ECP   = 3'b011,
    MD_RSV4  = 3'b100,
    MD_RSV5  = 3'b101,
    MD_TEST  = 3'b110,
    MD_CFG   = 3'b111
  } pp_mode_e;

  localparam logic [1:0] ADR_CFGA = 2'd0;
  localparam logic [1:0] ADR_CFGB = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;

  localparam logic [BYTE_W-1:0] CFGA_VAL = 8'h10;
  localparam logic [BYTE_W-1:0] CFGB_VAL = 8'h00;

  function automatic logic mode_moves_data(input pp_mode_e m);
    return (m == MD_PFIFO) || (m == MD_ECP) || (m == MD_TEST);
  endfunction

  function automatic logic mode_is_plain(input logic [2:0] m);
    return m[2:1] == 2'b00;
  endfunction

endpackage

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [W-1:0]  push_data,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full       = (count_q == DEPTH_C);
  assign empty      = (count_q == '0);
  assign push_ready = !full;
  assign pop_valid  = !empty;
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign pop_data   = mem[rd_ptr];
  assign count      = count_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DEPTH_C); // R3

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && do_push && !do_pop) |=> (count_q == $past(count_q) + 1'b1)); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R12

endmodule

// File: rtl/pp_svc_ctrl.sv
module pp_svc_ctrl #(
  parameter int DEPTH = 16,
  parameter int WR_TH = 8,
  parameter int RD_TH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_active,
  input  logic          dma_en,
  input  logic          dir_rev,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic          full,
  input  logic          dma_tc,
  input  logic          sw_wr,
  input  logic          sw_val,
  output logic          svc_q,
  output logic          svc_irq,
  output logic          dma_req
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] WR_TH_C = CW'(WR_TH);
  localparam logic [CW-1:0] RD_TH_C = CW'(RD_TH);

  logic          cond;
  logic [CW-1:0] free_slots;

  assign free_slots = DEPTH_C - count;

  always_comb begin
    if (!fifo_active)  cond = 1'b0;
    else if (dma_en)   cond = dma_tc;
    else if (dir_rev)  cond = (count >= RD_TH_C);
    else               cond = (free_slots >= WR_TH_C);
  end

  assign svc_irq = cond && !svc_q;
  assign dma_req = fifo_active && dma_en && !svc_q && (dir_rev ? !empty : !full);

  always_ff @(posedge clk) begin
    if (!rst_n)       svc_q <= 1'b1;
    else if (svc_irq) svc_q <= 1'b1;
    else if (sw_wr)   svc_q <= sw_val;
  end

  AST_SVC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |=> svc_q); // R5

  AST_SVC_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |-> (!svc_irq && !dma_req)); // R8

  AST_DMA_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req); // R7

endmodule

// File: rtl/pp_fault_irq.sv
module pp_fault_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ecp_active,
  input  logic mask_q,
  input  logic mask_wr,
  input  logic mask_wval,
  input  logic fault_n,
  output logic err_irq
);

  logic fault_q;
  logic fell;
  logic unmask;

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b1;
    else        fault_q <= fault_n;
  end

  assign fell    = fault_q && !fault_n;
  assign unmask  = mask_wr && mask_q && !mask_wval;
  assign err_irq = ecp_active && !fault_n && ((!mask_q && fell) || unmask);

  AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !mask_wr) |-> !err_irq); // R9

  AST_ERR_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !fault_n); // R10

endmodule

// File: rtl/ecp_fifo_ctrl.sv
module ecp_fifo_ctrl
  import ecp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WR_TH = 8,
  parameter int RD_TH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              dir_rev,
  input  logic              host_wvalid,
  output logic              host_wready,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              host_rvalid,
  input  logic              host_rready,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              per_wvalid,
  output logic              per_wready,
  input  logic [BYTE_W-1:0] per_wdata,
  output logic              per_rvalid,
  input  logic              per_rready,
  output logic [BYTE_W-1:0] per_rdata,
  input  logic              dma_tc,
  output logic              dma_req,
  output logic              svc_irq,
  input  logic              fault_n,
  output logic              err_irq
);

  localparam int CW = $clog2(DEPTH + 1);

  pp_mode_e          mode_q;
  logic              mask_q, dma_en_q, svc_q;
  logic              ctrl_wr, flush;
  logic              fifo_on, test_on;
  logic              host_fills, per_fills, host_drains, per_drains;
  logic              push_valid, push_ready, pop_valid, pop_ready;
  logic [BYTE_W-1:0] push_data, pop_data;
  logic [CW-1:0]     count;
  logic              empty, full;
  logic [BYTE_W-1:0] ctrl_byte;
  logic              unused_ro_bits;

  assign unused_ro_bits = ^reg_wdata[1:0];

  assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
  assign flush   = ctrl_wr && mode_is_plain(reg_wdata[7:5]) && !mode_is_plain(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MD_STD;
      mask_q   <= 1'b0;
      dma_en_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q   <= pp_mode_e'(reg_wdata[7:5]);
      mask_q   <= reg_wdata[4];
      dma_en_q <= reg_wdata[3];
    end
  end

  assign fifo_on     = mode_moves_data(mode_q);
  assign test_on     = (mode_q == MD_TEST);
  assign host_fills  = fifo_on && (test_on || !dir_rev);
  assign per_fills   = fifo_on && !test_on && dir_rev;
  assign host_drains = fifo_on && (test_on || dir_rev);
  assign per_drains  = fifo_on && !test_on && !dir_rev;

  always_comb begin
    push_valid = 1'b0;
    push_data  = host_wdata;
    if (host_fills) begin
      push_valid = host_wvalid;
    end else if (per_fills) begin
      push_valid = per_wvalid;
      push_data  = per_wdata;
    end
  end

  assign host_wready = host_fills && push_ready;
  assign per_wready  = per_fills && push_ready;
  assign host_rvalid = host_drains && pop_valid;
  assign per_rvalid  = per_drains && pop_valid;
  assign pop_ready   = (host_drains && host_rready) || (per_drains && per_rready);
  assign host_rdata  = pop_data;
  assign per_rdata   = pop_data;

  pp_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .pop_data   (pop_data),
    .count      (count),
    .empty      (empty),
    .full       (full)
  );

  pp_svc_ctrl #(.DEPTH(DEPTH), .WR_TH(WR_TH), .RD_TH(RD_TH)) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_active (fifo_on),
    .dma_en      (dma_en_q),
    .dir_rev     (dir_rev),
    .count       (count),
    .empty       (empty),
    .full        (full),
    .dma_tc      (dma_tc),
    .sw_wr       (ctrl_wr),
    .sw_val      (reg_wdata[2]),
    .svc_q       (svc_q),
    .svc_irq     (svc_irq),
    .dma_req     (dma_req)
  );

  pp_fault_irq u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecp_active (mode_q == MD_ECP),
    .mask_q     (mask_q),
    .mask_wr    (ctrl_wr),
    .mask_wval  (reg_wdata[4]),
    .fault_n    (fault_n),
    .err_irq    (err_irq)
  );

  assign ctrl_byte = {mode_q, mask_q, dma_en_q, svc_q, full, empty};

  always_comb begin
    case (reg_addr)
      ADR_CFGA: reg_rdata = (mode_q == MD_CFG) ? CFGA_VAL : '0;
      ADR_CFGB: reg_rdata = (mode_q == MD_CFG) ? CFGB_VAL : '0;
      ADR_CTRL: reg_rdata = ctrl_byte;
      default:  reg_rdata = '0;
    endcase
  end

  AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(mode_q)); // R12

  AST_PLAIN_MODE_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |-> !(host_wready || per_wready || host_rvalid || per_rvalid)); // R4

endmodule

// File: tb/ecp_fifo_ctrl_tb.sv
module ecp_fifo_ctrl_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       dir_rev;
  logic       host_wvalid, host_wready, host_rvalid, host_rready;
  logic [7:0] host_wdata, host_rdata;
  logic       per_wvalid, per_wready, per_rvalid, per_rready;
  logic [7:0] per_wdata, per_rdata;
  logic       dma_tc, dma_req, svc_irq, fault_n, err_irq;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  ecp_fifo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_rev(dir_rev),
    .host_wvalid(host_wvalid), .host_wready(host_wready), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rready(host_rready), .host_rdata(host_rdata),
    .per_wvalid(per_wvalid), .per_wready(per_wready), .per_wdata(per_wdata),
    .per_rvalid(per_rvalid), .per_rready(per_rready), .per_rdata(per_rdata),
    .dma_tc(dma_tc), .dma_req(dma_req), .svc_irq(svc_irq),
    .fault_n(fault_n), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ecr_write(input logic [7:0] v);
    reg_addr = 2'd2; reg_wdata = v; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [1:0] a, input logic [7:0] expv, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, expv);
    step();
  endtask

  // driver: host side fill, expected bytes go to the scoreboard
  task automatic host_push(input logic [7:0] b, input bit enq);
    bit done = 0;
    host_wvalid = 1'b1; host_wdata = b;
    while (!done) begin
      @(negedge clk);
      done = host_wready;
      step();
    end
    host_wvalid = 1'b0;
    if (enq) exp_q.push_back(b);
  endtask

  task automatic per_push(input logic [7:0] b);
    bit done = 0;
    per_wvalid = 1'b1; per_wdata = b;
    while (!done) begin
      @(negedge clk);
      done = per_wready;
      step();
    end
    per_wvalid = 1'b0;
    exp_q.push_back(b);
  endtask

  task automatic host_drain(input int n);
    int k = 0;
    host_rready = 1'b1;
    while (k < n) begin
      @(negedge clk);
      if (host_rvalid) k++;
      step();
    end
    host_rready = 1'b0;
  endtask

  // monitor: compares every host-side read against the scoreboard (R3)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && host_rvalid && host_rready) begin
      if (exp_q.size() == 0) chk("R3 unexpected host read", host_rdata, 32'hxx);
      else chk("R3 host read order", host_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0; dir_rev = 0;
    host_wvalid = 0; host_wdata = 0; host_rready = 0;
    per_wvalid = 0; per_wdata = 0; per_rready = 0; dma_tc = 0; fault_n = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    reg_addr = 2'd2;
    @(negedge clk);
    chk("R1 ctrl reset", reg_rdata, 8'h05);
    chk("R1 irq/dma idle", {svc_irq, dma_req, err_irq}, 3'b000);
    step();
    reg_check(2'd0, 8'h00, "R11 cfgA outside cfg mode");

    // R11 config mode; R2 ignored low bits
    ecr_write(8'hE0);
    reg_check(2'd0, 8'h10, "R11 cfgA");
    reg_check(2'd1, 8'h00, "R11 cfgB");
    reg_addr = 2'd0; reg_wdata = 8'hFF; reg_wr = 1'b1; step(); reg_wr = 1'b0;
    reg_check(2'd0, 8'h10, "R11 cfgA write ignored");
    ecr_write(8'hE3);
    reg_check(2'd2, 8'hE1, "R2 low bits ignored");

    // R3 test mode order and full
    ecr_write(8'hC4);
    host_push(8'h44, 1); host_push(8'h33, 1); host_push(8'h22, 1);
    reg_check(2'd2, 8'hC4, "R2 not empty");
    dir_rev = 1'b1;
    host_drain(3);
    dir_rev = 1'b0;
    for (int i = 0; i < 16; i++) host_push(8'h80 + 8'(i), 1);
    reg_check(2'd2, 8'hC6, "R2 full flag");
    host_wvalid = 1'b1;
    @(negedge clk);
    chk("R3 backpressure when full", host_wready, 1'b0);
    step();
    host_wvalid = 1'b0;
    host_drain(16);
    reg_check(2'd2, 8'hC5, "R2 empty after drain");
    chk("R3 scoreboard drained", exp_q.size(), 0);

    // R5 forward threshold, R4 routing
    ecr_write(8'h44);
    for (int i = 0; i < 9; i++) host_push(8'hA0 + 8'(i), 0);
    ecr_write(8'h40);
    @(negedge clk);
    chk("R5 free 7 below threshold", svc_irq, 1'b0);
    step();
    per_rready = 1'b1;
    @(negedge clk);
    chk("R4 peripheral drains forward", {per_rvalid, per_rdata}, {1'b1, 8'hA0});
    chk("R4 host sees no read forward", host_rvalid, 1'b0);
    step();
    per_rready = 1'b0;
    @(negedge clk);
    chk("R5 free 8 raises irq", svc_irq, 1'b1);
    step();
    reg_check(2'd2, 8'h44, "R8 service bit set by hw");
    chk("R8 irq low after set", svc_irq, 1'b0);

    // R12 flush
    ecr_write(8'h04);
    exp_q.delete();
    reg_check(2'd2, 8'h05, "R12 flush to empty");
    host_wvalid = 1'b1;
    @(negedge clk);
    chk("R4 no flow in mode 000", host_wready, 1'b0);
    step();
    host_wvalid = 1'b0;

    // R6 reverse threshold
    dir_rev = 1'b1;
    ecr_write(8'h64);
    host_wvalid = 1'b1;
    @(negedge clk);
    chk("R4 host cannot fill reverse", host_wready, 1'b0);
    step();
    host_wvalid = 1'b0;
    for (int i = 0; i < 7; i++) per_push(8'h10 + 8'(i));
    ecr_write(8'h60);
    @(negedge clk);
    chk("R6 seven bytes below threshold", svc_irq, 1'b0);
    step();
    per_push(8'h17);
    @(negedge clk);
    chk("R6 eight bytes raise irq", svc_irq, 1'b1);
    step();
    host_drain(8);
    ecr_write(8'h24);
    exp_q.delete();

    // R7 DMA
    dir_rev = 1'b0;
    ecr_write(8'h68);
    @(negedge clk);
    chk("R7 dma_req when not full", dma_req, 1'b1);
    chk("R7 thresholds ignored in dma", svc_irq, 1'b0);
    step();
    dma_tc = 1'b1;
    @(negedge clk);
    chk("R7 terminal count irq", svc_irq, 1'b1);
    step();
    dma_tc = 1'b0;
    @(negedge clk);
    chk("R8 dma held off by service bit", dma_req, 1'b0);
    step();
    ecr_write(8'h60);
    @(negedge clk);
    chk("R7 dma disabled", dma_req, 1'b0);
    step();

    // R9 / R10 fault
    ecr_write(8'h64);
    fault_n = 1'b0;
    @(negedge clk);
    chk("R9 fault edge pulse", err_irq, 1'b1);
    step();
    @(negedge clk);
    chk("R9 pulse one cycle", err_irq, 1'b0);
    step();
    fault_n = 1'b1; step();
    ecr_write(8'h74);
    fault_n = 1'b0;
    @(negedge clk);
    chk("R9 masked edge", err_irq, 1'b0);
    step();
    reg_addr = 2'd2; reg_wdata = 8'h64; reg_wr = 1'b1;
    @(negedge clk);
    chk("R10 unmask while fault low", err_irq, 1'b1);
    step();
    reg_wr = 1'b0;
    @(negedge clk);
    chk("R10 pulse ends", err_irq, 1'b0);
    step();
    fault_n = 1'b1; step();
    ecr_write(8'h44);
    fault_n = 1'b0;
    @(negedge clk);
    chk("R9 no pulse outside ECP mode", err_irq, 1'b0);
    step();
    fault_n = 1'b1;

    repeat (2) step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule